// File: doc/BRIEF.md
# Latched Channel-Select Controller with Break-Before-Make

This block drives the switch enables of an eight-way analog selector. The selector can run as eight single-ended channels or as four channel pairs. A host presents a binary channel number and an enable bit, then pulses an active-low write strobe. While the strobe is low, internal holding registers follow the inputs. When the strobe returns high, they keep the last value. The held value is decoded into a one-hot switch-enable vector. In pair mode, the a-side and the b-side line of the chosen pair are both driven.

The switches must never short two sources together, so every move from one selection to a different one goes through a gap in which all outputs are off. The gap length is set by a parameter. A selection that only opens switches acts at once. An active-low master clear empties the holding registers and opens every switch, whatever the other inputs are doing.

The clear, the strobe, the channel number, the enable and the mode input are each brought into the clock domain through two flip-flops.

Top module: `chsel_ctrl`

## Requirements
- R1: In single-ended mode (`diff_mode`=0), a held enable of 1 with held channel number k drives `sw_en[k]` alone. Bit k is channel k+1.
- R2: In pair mode (`diff_mode`=1), held channel number bits [1:0] = p drive `sw_en[p]` (a-side) and `sw_en[p+4]` (b-side) together. Bit 2 of the channel number has no effect.
- R3: While `wr_n` is low, the holding registers follow `addr_in` and `en_in`. An input change first reaches `sw_en` four clock edges after it is applied, because of two synchroniser stages, one holding stage and one output stage.
- R4: While `wr_n` is high, changes on `addr_in` and `en_in` leave `sw_en` unchanged.
- R5: The enable bit is held together with the channel number. A held enable of 0 turns every output off.
- R6: While `rst_n` is low, `sw_en` is all zero from the first clock edge on, even if `wr_n` is low and `en_in` is 1. After release with `wr_n` high, `sw_en` stays zero until a new write.
- R7: `sw_en` never changes directly from one non-zero value to a different non-zero value.
- R8: A new non-zero value appears only after `sw_en` has been all zero for `BBM_CYCLES` clock cycles. With a steady write, it appears 4 + `BBM_CYCLES` edges after the input change.
- R9: A selection change that arrives during a gap restarts the gap. The newest selection is the one applied, and the one it replaced never appears.
- R10: A change to an all-off selection (enable cleared) reaches `sw_en` four edges after it is applied, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master clear, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low; low makes the holding registers transparent |
| en_in | input | 1 | Enable bit, held with the channel number |
| addr_in | input | $clog2(NCH) | Binary channel number |
| diff_mode | input | 1 | 0 = single-ended, 1 = channel pairs |
| sw_en | output | NCH | Switch enables; in pair mode the low half is the a-side and the high half the b-side |

## Verification
The assertions assume that `diff_mode` is a static strap and that `addr_in`, `en_in` and `diff_mode` are held steady whenever a write starts or ends. This matters because the synchronisers pass them independently, and a mismatched sample could otherwise be held. The stimulus changes the channel number, the enable and the mode only at negative edges, either together with the strobe falling or while the strobe stays low. It raises the strobe only after at least three clock cycles of steady inputs. The mode is changed only at a write, and a full gap time follows before the next check.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  // operating mode of the selector
  typedef enum logic {
    SEL_SINGLE = 1'b0,
    SEL_DIFF   = 1'b1
  } sel_mode_e;

endpackage

// File: rtl/chsel_rst_sync.sv
// Reset bridge: clear asserts at once, releases after two clock edges.
module chsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic clr
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign clr = ~stage[1];

endmodule

// File: rtl/chsel_sync.sv
// Two-flop synchroniser for a group of control inputs.
module chsel_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (clr) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/chsel_latch.sv
// Holding registers for the channel number and enable; transparent while
// the synchronised strobe is low, frozen while it is high.
module chsel_latch #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_low,
  input  logic          d_en,
  input  logic [AW-1:0] d_addr,
  output logic          q_en,
  output logic [AW-1:0] q_addr
);

  always_ff @(posedge clk) begin
    if (clr) begin
      q_en   <= 1'b0;
      q_addr <= '0;
    end else if (wr_low) begin
      q_en   <= d_en;
      q_addr <= d_addr;
    end
  end

  AST_HOLD_WHEN_HIGH: assert property (@(posedge clk) disable iff (clr)
    !wr_low |=> ($stable(q_en) && $stable(q_addr))); // R4

endmodule

// File: rtl/chsel_decode.sv
// Turns the held selection into switch enables for either mode.
module chsel_decode
  import chsel_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = $clog2(NCH)
) (
  input  sel_mode_e      mode,
  input  logic           en,
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] onehot
);
  localparam int HALF = NCH / 2;
  localparam int PW   = AW - 1;

  logic [NCH-1:0] se_vec;
  logic [NCH-1:0] df_vec;

  for (genvar i = 0; i < NCH; i++) begin : g_line
    assign se_vec[i] = en && (addr == AW'(i));
    assign df_vec[i] = en && (addr[PW-1:0] == PW'(i % HALF));
  end

  assign onehot = (mode == SEL_DIFF) ? df_vec : se_vec;

endmodule

// File: rtl/chsel_bbm.sv
// Output sequencer: opens everything, waits BBM_CYCLES, then closes the
// newly requested switches. Opening-only requests act immediately.
module chsel_bbm #(
  parameter int NCH        = 8,
  parameter int BBM_CYCLES = 2
) (
  input  logic           clk,
  input  logic           clr,
  input  logic [NCH-1:0] target,
  output logic [NCH-1:0] sw_q
);
  localparam int CW = $clog2(BBM_CYCLES + 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(BBM_CYCLES);

  logic [CW-1:0]  gap_cnt;
  logic [NCH-1:0] pend;

  always_ff @(posedge clk) begin
    if (clr) begin
      sw_q    <= '0;
      gap_cnt <= '0;
      pend    <= '0;
    end else if (target == '0) begin
      sw_q    <= '0;
      gap_cnt <= '0;
      pend    <= '0;
    end else if (gap_cnt != '0) begin
      if (target != pend) begin
        pend    <= target;
        gap_cnt <= GAP_LOAD;
      end else if (gap_cnt == CW'(1)) begin
        sw_q    <= pend;
        gap_cnt <= '0;
      end else begin
        gap_cnt <= gap_cnt - CW'(1);
      end
    end else if (target != sw_q) begin
      sw_q    <= '0;
      pend    <= target;
      gap_cnt <= GAP_LOAD;
    end
  end

  // checker state: length of the current all-off run, saturating
  logic [CW-1:0] off_run;
  always_ff @(posedge clk) begin
    if (clr)                     off_run <= '0;
    else if (sw_q != '0)         off_run <= '0;
    else if (off_run < GAP_LOAD) off_run <= off_run + CW'(1);
  end

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (clr)
    (sw_q != '0) |=> (sw_q == '0 || $stable(sw_q))); // R7

  AST_GAP_BEFORE_CLOSE: assert property (@(posedge clk) disable iff (clr)
    (sw_q != '0 && $past(sw_q) == '0) |-> (off_run >= GAP_LOAD)); // R8

  AST_OPEN_AT_ONCE: assert property (@(posedge clk) disable iff (clr)
    (target == '0) |=> (sw_q == '0)); // R10

  AST_CLEAR_OPENS: assert property (@(posedge clk)
    clr |=> (sw_q == '0)); // R6

endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
  import chsel_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int BBM_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_n,
  input  logic                    en_in,
  input  logic [$clog2(NCH)-1:0]  addr_in,
  input  logic                    diff_mode,
  output logic [NCH-1:0]          sw_en
);
  localparam int AW   = $clog2(NCH);
  localparam int HALF = NCH / 2;
  localparam int DW   = AW + 2;

  logic          clr;
  logic          wr_n_s;
  logic [DW-1:0] data_s;
  logic          lat_en;
  logic [AW-1:0] lat_addr;
  sel_mode_e     mode;
  logic [NCH-1:0] target;

  chsel_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr)
  );

  chsel_sync #(.W(1), .RST_VAL(1'b1)) u_wr_sync (
    .clk (clk),
    .clr (clr),
    .d   (wr_n),
    .q   (wr_n_s)
  );

  chsel_sync #(.W(DW), .RST_VAL('0)) u_data_sync (
    .clk (clk),
    .clr (clr),
    .d   ({diff_mode, en_in, addr_in}),
    .q   (data_s)
  );

  assign mode = data_s[DW-1] ? SEL_DIFF : SEL_SINGLE;

  chsel_latch #(.AW(AW)) u_latch (
    .clk    (clk),
    .clr    (clr),
    .wr_low (~wr_n_s),
    .d_en   (data_s[AW]),
    .d_addr (data_s[AW-1:0]),
    .q_en   (lat_en),
    .q_addr (lat_addr)
  );

  chsel_decode #(.NCH(NCH), .AW(AW)) u_decode (
    .mode   (mode),
    .en     (lat_en),
    .addr   (lat_addr),
    .onehot (target)
  );

  chsel_bbm #(.NCH(NCH), .BBM_CYCLES(BBM_CYCLES)) u_bbm (
    .clk    (clk),
    .clr    (clr),
    .target (target),
    .sw_q   (sw_en)
  );

  AST_ONE_CHANNEL_OR_PAIR: assert property (@(posedge clk) disable iff (clr)
    $onehot0(sw_en) ||
    (sw_en[NCH-1:HALF] == sw_en[HALF-1:0] && $onehot0(sw_en[HALF-1:0]))); // R1 R2

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (clr)
    (!lat_en) |=> (sw_en == '0)); // R5

endmodule

// File: tb/tb_chsel_ctrl.sv
module tb_chsel_ctrl;
  localparam int NCH = 8;
  localparam int BBM = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_n;
  logic       en_in;
  logic [2:0] addr_in;
  logic       diff_mode;
  logic [7:0] sw_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  chsel_ctrl #(.NCH(NCH), .BBM_CYCLES(BBM)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .en_in     (en_in),
    .addr_in   (addr_in),
    .diff_mode (diff_mode),
    .sw_en     (sw_en)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic       diff;
    logic       en;
    logic [2:0] addr;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 3'd0, 8'h01},  // R1
    '{1'b0, 1'b1, 3'd3, 8'h08},  // R1
    '{1'b0, 1'b1, 3'd7, 8'h80},  // R1
    '{1'b0, 1'b0, 3'd2, 8'h00},  // R5
    '{1'b0, 1'b1, 3'd5, 8'h20},  // R1
    '{1'b1, 1'b1, 3'd0, 8'h11},  // R2
    '{1'b1, 1'b1, 3'd3, 8'h88},  // R2
    '{1'b1, 1'b1, 3'd6, 8'h44},  // R2 bit 2 ignored
    '{1'b1, 1'b1, 3'd5, 8'h22},  // R2 bit 2 ignored
    '{1'b1, 1'b0, 3'd1, 8'h00},  // R5
    '{1'b0, 1'b1, 3'd1, 8'h02}   // R1
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sw_en=%02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic d, input logic e, input logic [2:0] a);
    diff_mode = d; en_in = e; addr_in = a; wr_n = 1'b0;
    tick(3);
    wr_n = 1'b1;
    tick(14);
  endtask

  // monitor: break-before-make and shape, checked at every rise of a selection
  logic [7:0] prev_sw = 8'h00;
  int         off_len = 0;
  always @(negedge clk) begin
    if (sw_en != 8'h00 && prev_sw != 8'h00 && sw_en != prev_sw) begin
      n_chk++; n_bad++;
      $display("FAIL R7: sw_en=%02h after %02h expected 00 between", sw_en, prev_sw);
    end
    if (sw_en != 8'h00 && prev_sw == 8'h00) begin
      n_chk++;
      if (off_len < BBM) begin
        n_bad++;
        $display("FAIL R8: all-off run=%0d expected >=%0d", off_len, BBM);
      end
      n_chk++;
      if (!($onehot(sw_en) || (sw_en[7:4] == sw_en[3:0] && $onehot(sw_en[3:0])))) begin
        n_bad++;
        $display("FAIL R1/R2: sw_en=%02h expected one line or one pair", sw_en);
      end
    end
    off_len = (sw_en == 8'h00) ? off_len + 1 : 0;
    prev_sw = sw_en;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: cycles=%0d expected <20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  bit seen_old;

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; en_in = 1'b0; addr_in = 3'd0; diff_mode = 1'b0;
    tick(4);
    check("R6 reset state", sw_en, 8'h00);
    rst_n = 1'b1;
    tick(4);
    check("R6 off after release", sw_en, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      write_sel(VEC[i].diff, VEC[i].en, VEC[i].addr);
      check("R1/R2/R5 table", sw_en, VEC[i].exp);
    end

    // exact latency of a change: SE channel 1 -> channel 3
    write_sel(1'b0, 1'b1, 3'd0);
    check("R1 start", sw_en, 8'h01);
    addr_in = 3'd2; wr_n = 1'b0;
    tick(3);  check("R3 sync latency", sw_en, 8'h01);
    tick(1);  check("R3 R7 open at edge 4", sw_en, 8'h00);
    tick(3);  check("R8 still in gap", sw_en, 8'h00);
    tick(1);  check("R8 close after gap", sw_en, 8'h04);
    wr_n = 1'b1;
    tick(6);

    // hold: inputs move while strobe high
    addr_in = 3'd6; en_in = 1'b0;
    tick(14);
    check("R4 hold while wr_n high", sw_en, 8'h04);

    // restart of gap: request 5, then 1 during the gap
    en_in = 1'b1; addr_in = 3'd5; wr_n = 1'b0;
    seen_old = 1'b0;
    tick(3);
    addr_in = 3'd1;
    for (int k = 0; k < 7; k++) begin
      tick(1);
      if (sw_en == 8'h20) seen_old = 1'b1;
    end
    check("R9 still off before restarted gap ends", sw_en, 8'h00);
    tick(1);
    check("R9 newest applied", sw_en, 8'h02);
    n_chk++;
    if (seen_old) begin
      n_bad++;
      $display("FAIL R9: superseded value 20 appeared expected never");
    end
    wr_n = 1'b1;
    tick(6);

    // immediate open on enable cleared
    en_in = 1'b0; wr_n = 1'b0;
    tick(3);  check("R10 before arrival", sw_en, 8'h02);
    tick(1);  check("R10 open without gap", sw_en, 8'h00);
    wr_n = 1'b1;
    tick(6);

    // reset priority over an active write
    write_sel(1'b0, 1'b1, 3'd3);
    check("R6 pre-reset select", sw_en, 8'h08);
    wr_n = 1'b0; en_in = 1'b1; addr_in = 3'd4;
    rst_n = 1'b0;
    tick(1);  check("R6 off at first edge", sw_en, 8'h00);
    tick(8);  check("R6 write ignored in reset", sw_en, 8'h00);
    wr_n = 1'b1;
    tick(1);
    rst_n = 1'b1;
    tick(14);
    check("R6 latches cleared", sw_en, 8'h00);
    write_sel(1'b0, 1'b1, 3'd3);
    check("R1 recovery after reset", sw_en, 8'h08);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule